// File: doc/BRIEF.md
# Auto-Refresh Scheduler With Burst Control

This block decides when an SDRAM controller must issue auto-refresh commands. Software writes one configuration word that holds a reload value for a down-counter and a two-bit burst mode. While refresh is enabled, the counter runs down once per clock. Each time it runs out, the block owes one burst of refreshes: one, four or eight, depending on the mode. The owed refreshes are offered to the command arbiter on a request/grant handshake. Expiries that arrive while earlier bursts are still owed are queued rather than lost.

The block follows the self-refresh state reported by the power sequencer, so software never has to switch auto-refresh off around self-refresh. While the memory is in self-refresh, the block raises no request, and whatever is owed is cleared. When self-refresh ends, the counter restarts from its reload value and one refresh is forced. A block-other-commands output stays high until the arbiter grants that forced refresh, so the refresh is the first command the memory sees after the exit.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset, `ref_req` and `blk_cmd` are low and refresh is disabled (mode 00).
- R2: A configuration write takes the reload value from `cfg_wdata[23:8]` and the mode from `cfg_wdata[1:0]`. All other bits are ignored, and the write restarts the counter at the reload value.
- R3: With mode 00, no periodic request is raised, and anything still owed is dropped on the write that selects mode 00.
- R4: Modes 01, 10 and 11 owe bursts of 1, 4 and 8 granted refreshes per counter expiry.
- R5: With reload value N, the counter expires every N+1 clocks. After a write at edge k, `ref_req` first rises after edge k+N+1, and the next expiry follows N+1 edges after that.
- R6: Up to 8 owed bursts are held. Expiries beyond that are not added, and all held bursts are served in turn.
- R7: While `sr_active` is high, `ref_req` is low, and no owed refreshes build up.
- R8: On the clock after `sr_active` falls, `ref_req` and `blk_cmd` go high. `blk_cmd` stays high until that forced refresh is granted and then drops. The forced grant does not count against owed bursts.
- R9: The edge that sees `sr_active` fall restarts the counter, so the next periodic expiry follows N+1 edges later, whatever the count was before self-refresh.
- R10: Outside self-refresh and configuration writes, a raised `ref_req` stays high until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: reload [23:8], mode [1:0] |
| sr_active | input | 1 | Memory is in self-refresh (level) |
| ref_req | output | 1 | Refresh request to the command arbiter |
| ref_gnt | input | 1 | Arbiter grants the refresh in this cycle |
| blk_cmd | output | 1 | Hold off all other commands |

## Verification
The hardest state to reach is a full queue of owed bursts. It only builds up when expiries outrun grants for many periods. The bench gets there by setting a reload of zero so the counter expires on every clock, withholding grants, and then writing a large reload to freeze further expiries before counting the grants. The exit from self-refresh is also reached with a stale counter value and a pending expiry in flight. This shows that the forced refresh comes first and that the periodic schedule restarts from the exit edge.

// File: rtl/refsched_pkg.sv
// Shared types for the refresh scheduler: burst-mode encoding and
// the burst length each mode asks for. Assumes no burst exceeds 8.
package refsched_pkg;

    typedef enum logic [1:0] {
        ARF_OFF = 2'b00,
        ARF_X1  = 2'b01,
        ARF_X4  = 2'b10,
        ARF_X8  = 2'b11
    } arf_mode_e;

    localparam int BURST_MAX = 8;
    localparam int BLEN_W    = $clog2(BURST_MAX) + 1;

    // Number of refreshes owed per expiry for a mode.
    function automatic logic [BLEN_W-1:0] burst_len(arf_mode_e m);
        case (m)
            ARF_X1:  return BLEN_W'(1);
            ARF_X4:  return BLEN_W'(4);
            ARF_X8:  return BLEN_W'(8);
            default: return BLEN_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/refsched_timer.sv
// Down-counter that pulses expire when it has run to zero and reloads.
// Assumes restart has priority: a restart cycle never reports expiry.
module refsched_timer #(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                restart,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expire
);

    logic [RELOAD_W-1:0] cnt_q;

    // Count down while running; reload on restart, stop or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - RELOAD_W'(1);
        end
    end

    // Expiry is the zero state of a running, non-restarted counter.
    always_comb begin
        expire = run && !restart && (cnt_q == '0);
    end

endmodule

// File: rtl/refsched_queue.sv
// Holds owed refresh bursts (saturating at DEPTH) and tracks the beat
// within the burst in service. Assumes blen >= 1 whenever grants arrive.
module refsched_queue #(
    parameter int DEPTH  = 8,
    parameter int BLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              expire,
    input  logic              grant,
    input  logic [BLEN_W-1:0] blen,
    output logic              busy
);

    localparam int PEND_W = $clog2(DEPTH + 1);
    localparam int BEAT_W = BLEN_W - 1;

    logic [PEND_W-1:0] pend_q;
    logic [BEAT_W-1:0] beat_q;
    logic              last_beat;
    logic              dec;
    logic              inc;

    // Decide whether this grant ends a burst and whether an expiry fits.
    always_comb begin
        last_beat = (BLEN_W'(beat_q) + BLEN_W'(1)) >= blen;
        dec       = grant && last_beat;
        inc       = expire && ((pend_q < PEND_W'(DEPTH)) || dec);
        busy      = (pend_q != '0);
    end

    // Update the owed-burst count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pend_q <= '0;
        end else if (inc && !dec) begin
            pend_q <= pend_q + PEND_W'(1);
        end else if (dec && !inc) begin
            pend_q <= pend_q - PEND_W'(1);
        end
    end

    // Step the beat counter on each grant, wrapping at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            beat_q <= '0;
        end else if (grant) begin
            beat_q <= last_beat ? '0 : beat_q + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/refsched_force.sv
// Detects the end of self-refresh and keeps a forced refresh pending
// until granted. Assumes sr_active is synchronous to clk.
module refsched_force (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_active,
    input  logic grant,
    output logic sr_exit,
    output logic forced
);

    logic sr_prev_q;

    // Remember the previous self-refresh level.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_prev_q <= 1'b0;
        else        sr_prev_q <= sr_active;
    end

    // Exit is the falling edge of the self-refresh level.
    always_comb begin
        sr_exit = sr_prev_q && !sr_active;
    end

    // Set on exit, clear on grant or on renewed self-refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || sr_active) forced <= 1'b0;
        else if (sr_exit)        forced <= 1'b1;
        else if (grant)          forced <= 1'b0;
    end

endmodule

// File: rtl/refresh_scheduler.sv
// Top of the auto-refresh scheduler. Holds the configuration word,
// runs the period timer, queues owed bursts and forces one refresh on
// self-refresh exit while blocking other commands.
// Assumes the arbiter grants only while ref_req is high.
module refresh_scheduler #(
    parameter int DATA_W     = 32,
    parameter int RELOAD_W   = 16,
    parameter int RELOAD_LSB = 8,
    parameter int PEND_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sr_active,
    output logic              ref_req,
    input  logic              ref_gnt,
    output logic              blk_cmd
);
    import refsched_pkg::*;

    logic [RELOAD_W-1:0] reload_q;
    arf_mode_e           mode_q;
    arf_mode_e           wr_mode;
    logic                expire;
    logic                sr_exit;
    logic                forced;
    logic                busy;
    logic                flush;
    logic                run;
    logic                gnt_force;
    logic                gnt_per;

    // Capture reload value and burst mode on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            mode_q   <= ARF_OFF;
        end else if (cfg_we) begin
            reload_q <= cfg_wdata[RELOAD_LSB +: RELOAD_W];
            mode_q   <= wr_mode;
        end
    end

    // Derive run, flush, grant routing and the output pins.
    always_comb begin
        wr_mode   = arf_mode_e'(cfg_wdata[1:0]);
        run       = (mode_q != ARF_OFF) && !sr_active;
        flush     = sr_active || (mode_q == ARF_OFF) ||
                    (cfg_we && wr_mode == ARF_OFF);
        ref_req   = !sr_active && (forced || busy);
        gnt_force = ref_gnt && forced && !sr_active;
        gnt_per   = ref_gnt && ref_req && !forced;
        blk_cmd   = forced;
    end

    refsched_timer #(
        .RELOAD_W (RELOAD_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cfg_we || sr_exit),
        .reload  (cfg_we ? cfg_wdata[RELOAD_LSB +: RELOAD_W] : reload_q),
        .expire  (expire)
    );

    refsched_queue #(
        .DEPTH  (PEND_DEPTH),
        .BLEN_W (BLEN_W)
    ) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .expire (expire),
        .grant  (gnt_per),
        .blen   (burst_len(mode_q)),
        .busy   (busy)
    );

    refsched_force u_force (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_active (sr_active),
        .grant     (gnt_force),
        .sr_exit   (sr_exit),
        .forced    (forced)
    );

endmodule

// File: rtl/refsched_checker.sv
// Port-level properties of the refresh scheduler, bound to its top.
module refsched_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_mode,
    input logic       sr_active,
    input logic       ref_req,
    input logic       ref_gnt,
    input logic       blk_cmd
);

    AST_QUIET_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req); // R7

    AST_EXIT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |=> (ref_req && blk_cmd)); // R8

    AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cmd && !ref_gnt && !sr_active) |=> (blk_cmd || sr_active)); // R8

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt && !cfg_we && !sr_active) |=> (ref_req || sr_active)); // R10

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == 2'b00 && !blk_cmd && !sr_active) |=> (!ref_req || blk_cmd)); // R3

endmodule

bind refresh_scheduler refsched_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_mode  (cfg_wdata[1:0]),
    .sr_active (sr_active),
    .ref_req   (ref_req),
    .ref_gnt   (ref_gnt),
    .blk_cmd   (blk_cmd)
);

// File: tb/refresh_scheduler_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module refresh_scheduler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sr_active = 1'b0;
    logic        ref_gnt = 1'b0;
    logic        ref_req;
    logic        blk_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    refresh_scheduler u_refresh_scheduler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sr_active (sr_active),
        .ref_req   (ref_req),
        .ref_gnt   (ref_gnt),
        .blk_cmd   (blk_cmd)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Write reload/mode; returns at the negedge after the capturing edge.
    task automatic cfg_write(int reload, int mode);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = 32'hA500_00FC | (32'(reload & 16'hFFFF) << 8) | 32'(mode & 3);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Grant every request until ref_req drops; return number of grants.
    task automatic drain(output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            if (!ref_req) break;
            n++;
            ref_gnt = 1'b1;
            @(negedge clk);
        end
        ref_gnt = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 req after reset", int'(ref_req), 0);
        check("R1 blk after reset", int'(blk_cmd), 0);
    endtask

    task automatic t_off;
        int seen = 0;
        cfg_write(2, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ref_req) seen++;
        end
        check("R3 requests with mode 00", seen, 0);
    endtask

    task automatic t_period;
        cfg_write(5, 1);
        wait_neg(5);
        check("R5 no req before N+1", int'(ref_req), 0);
        wait_neg(1);
        check("R2 R5 req at N+1", int'(ref_req), 1);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        check("R4 single grant clears", int'(ref_req), 0);
        wait_neg(4);
        check("R5 no req before second expiry", int'(ref_req), 0);
        wait_neg(1);
        check("R5 second expiry", int'(ref_req), 1);
        cfg_write(0, 0);
        check("R3 owed dropped on mode 00", int'(ref_req), 0);
    endtask

    task automatic t_burst(int mode, int exp_len);
        int n;
        cfg_write(0, 0);
        cfg_write(3, mode);
        for (int i = 0; i < 20; i++) begin
            if (ref_req) break;
            @(negedge clk);
        end
        cfg_write(1000, mode);
        drain(n);
        check($sformatf("R4 burst length mode %0d", mode), n, exp_len);
    endtask

    task automatic t_saturate;
        int n;
        cfg_write(0, 0);
        cfg_write(0, 1);
        wait_neg(15);
        cfg_write(1000, 1);
        drain(n);
        check("R6 owed bursts saturate at 8", n, 8);
    endtask

    task automatic t_selfref;
        int seen = 0;
        cfg_write(0, 0);
        cfg_write(20, 1);
        wait_neg(7);
        sr_active = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_req) seen++;
        end
        check("R7 no req in self-refresh", seen, 0);
        sr_active = 1'b0;
        @(negedge clk);
        check("R8 forced req after exit", int'(ref_req), 1);
        check("R8 block after exit", int'(blk_cmd), 1);
        wait_neg(2);
        check("R8 block held until grant", int'(blk_cmd), 1);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        check("R8 block drops after grant", int'(blk_cmd), 0);
        check("R7 R8 nothing owed after forced", int'(ref_req), 0);
        wait_neg(17);
        check("R9 no req before restart expiry", int'(ref_req), 0);
        wait_neg(1);
        check("R9 expiry N+1 after exit", int'(ref_req), 1);
        cfg_write(0, 0);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_period();
        t_burst(1, 1);
        t_burst(2, 4);
        t_burst(3, 8);
        t_saturate();
        t_selfref();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule